// File: doc/BRIEF.md
# Sum of Absolute Differences Unit

This unit is an unsigned integer arithmetic lane. It takes two 32-bit sources and a 32-bit accumulator, finds the absolute differences between the sources at a chosen lane width, and adds their sum to the accumulator. A 2-bit mode select picks one of four lane widths:

- four 8-bit lanes;
- two 16-bit lanes;
- one 32-bit lane;
- four 8-bit lanes with masking. In this mode a lane drops out of the sum when its byte in the first source is zero.

A valid strobe qualifies each operation. The result and an output valid flag come from registers one clock later. Block-matching and motion-search kernels can chain one result into the accumulator of the next operation.

Top module: `sad_unit`

## Requirements
- R1: Mode 2'b00 splits each source into four unsigned 8-bit lanes, where lane k is bits [8k+7:8k]. The result is the accumulator plus the sum of the four lane absolute differences.
- R2: Mode 2'b01 splits each source into two unsigned 16-bit lanes, bits [15:0] and [31:16]. The result is the accumulator plus the sum of the two lane absolute differences.
- R3: Mode 2'b10 adds the absolute difference of the two full 32-bit unsigned sources to the accumulator. The result is the same whichever source is larger.
- R4: Mode 2'b11 works as mode 2'b00, except that any byte lane whose first-source byte is zero adds nothing. When every first-source byte is zero, the result is the accumulator.
- R5: In mode 2'b11 with no zero byte in the first source, the result equals the mode 2'b00 result.
- R6: When both sources are equal, the result is the accumulator in every mode.
- R7: Lanes are always treated as unsigned. A lane of 8'h00 against 8'hFF contributes 255.
- R8: The final addition wraps modulo 2^32, with no saturation.
- R9: The result and out_valid appear one clock after in_valid is sampled high. out_valid is low after a cycle with in_valid low, and the result register holds its value.
- R10: A synchronous active-high reset clears out_valid and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Lane width select: 00 byte, 01 halfword, 10 word, 11 masked byte |
| src_a | input | 32 | First source; its bytes act as the mask in masked mode |
| src_b | input | 32 | Second source |
| acc | input | 32 | Accumulator operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Accumulator plus absolute-difference sum |

## Verification
Random operands in all four modes are checked against a reference function.

- Byte lanes of 00 against FF show whether each difference is taken as unsigned and in the right direction.
- Swapping which source is larger in word mode has the same purpose: a one-sided subtraction fails these cases.
- Masked mode is driven with scattered zero bytes, with every byte zero, and with no byte zero. These patterns separate the mask test from plain byte mode.
- Accumulators near 2^32 expose any missing wrap in the final addition.
- Equal sources must return the accumulator, which separates a correct sum from an offset error.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    SAD_BYTE   = 2'b00,
    SAD_HALF   = 2'b01,
    SAD_WORD   = 2'b10,
    SAD_MASKED = 2'b11
  } sad_mode_e;
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] d
);
  logic a_ge_b;
  always_comb begin
    a_ge_b = (a >= b);
    d      = a_ge_b ? (a - b) : (b - a);
  end

  // the difference never exceeds the larger operand
  always_comb begin
    assert (d <= (a_ge_b ? a : b)); // R7
  end
endmodule

// File: rtl/sad_lane_bank.sv
module sad_lane_bank #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              mask_en,
  output logic [DATA_W-1:0] sum
);
  localparam int N_LANES = DATA_W / LANE_W;

  logic [LANE_W-1:0] diff [N_LANES];
  logic [N_LANES-1:0] keep;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    sad_absdiff #(.LANE_W(LANE_W)) u_abs (
      .a(a[g*LANE_W +: LANE_W]),
      .b(b[g*LANE_W +: LANE_W]),
      .d(diff[g])
    );
    assign keep[g] = !(mask_en && (a[g*LANE_W +: LANE_W] == '0));
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_LANES; i++) begin
      if (keep[i]) sum = sum + DATA_W'(diff[i]);
    end
  end
endmodule

// File: rtl/sad_unit.sv
module sad_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] acc,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  import sad_pkg::*;

  sad_mode_e   mode_e;
  logic [DATA_W-1:0] sum_byte, sum_half, sum_word, diff_sum;
  logic        use_mask;

  assign mode_e   = sad_mode_e'(mode);
  assign use_mask = (mode_e == SAD_MASKED);

  sad_lane_bank #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_bytes (
    .a(src_a), .b(src_b), .mask_en(use_mask), .sum(sum_byte)
  );
  sad_lane_bank #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_halves (
    .a(src_a), .b(src_b), .mask_en(1'b0), .sum(sum_half)
  );
  sad_lane_bank #(.DATA_W(DATA_W), .LANE_W(DATA_W)) u_word (
    .a(src_a), .b(src_b), .mask_en(1'b0), .sum(sum_word)
  );

  always_comb begin
    unique case (mode_e)
      SAD_HALF: diff_sum = sum_half;
      SAD_WORD: diff_sum = sum_word;
      default:  diff_sum = sum_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= acc + diff_sum;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result))); // R9
  AST_SAME_SRC_ACC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_a == src_b) |=> (result == $past(acc))); // R6
  AST_MASK_ALL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b11 && src_a == '0) |=> (result == $past(acc))); // R4
  AST_WORD_FWD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b10 && src_a >= src_b) |=> (result == $past(acc + src_a - src_b))); // R3
endmodule

// File: tb/sad_unit_tb.sv
module sad_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [31:0] src_a = '0, src_b = '0, acc = '0;
  logic        out_valid;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  sad_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .src_a(src_a), .src_b(src_b), .acc(acc),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] ad(input logic [31:0] x, input logic [31:0] y);
    return (x > y) ? x - y : y - x;
  endfunction

  function automatic logic [31:0] ref_sad(input logic [1:0] m, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] c);
    logic [31:0] s = 0;
    case (m)
      2'b01: for (int i = 0; i < 2; i++) s += ad(32'(a[16*i +: 16]), 32'(b[16*i +: 16]));
      2'b10: s = ad(a, b);
      default:
        for (int i = 0; i < 4; i++)
          if (!(m == 2'b11 && a[8*i +: 8] == 0)) s += ad(32'(a[8*i +: 8]), 32'(b[8*i +: 8]));
    endcase
    return c + s;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // drive one op at a falling edge, check at the following falling edge
  task automatic run_op(input string req, input logic [1:0] m, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c, input logic [31:0] exp);
    mode = m; src_a = a; src_b = b; acc = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check(req, result, exp);
  endtask

  task automatic print_summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    logic [31:0] ra, rb, rc, last;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 32'(out_valid), 0);
    check("R10 reset result", result, 0);
    rst = 1'b0;
    @(negedge clk);

    run_op("R1", 2'b00, 32'h04030201, 32'h05040302, 0, 32'd4);
    run_op("R2", 2'b01, 32'h00030001, 32'h00050002, 0, 32'd3);
    run_op("R3", 2'b10, 32'd100, 32'd70, 0, 32'd30);
    run_op("R3 swapped", 2'b10, 32'd70, 32'd100, 0, 32'd30);
    run_op("R4", 2'b11, 32'h04000201, 32'h05040302, 0, 32'd3);
    run_op("R4 all zero", 2'b11, 32'h0, 32'hFFFFFFFF, 32'd7, 32'd7);
    run_op("R5", 2'b11, 32'h04030201, 32'h05040302, 0, 32'd4);
    run_op("R6", 2'b00, 32'h04030201, 32'h04030201, 32'd10, 32'd10);
    run_op("R7", 2'b00, 32'h00FF00FF, 32'hFF00FF00, 0, 32'd1020);
    run_op("R7 half", 2'b01, 32'h0000FFFF, 32'hFFFF0000, 0, 32'h1FFFE);
    run_op("R8", 2'b10, 32'd5, 32'd3, 32'hFFFFFFFF, 32'd1);
    run_op("R8 byte", 2'b00, 32'hFF, 32'h00, 32'hFFFFFF80, 32'h7F);

    // idle cycle with changed inputs: output must hold
    last = result;
    mode = 2'b10; src_a = 32'h12345678; src_b = 0; acc = 32'h55;
    @(negedge clk);
    check("R9 idle valid", 32'(out_valid), 0);
    check("R9 idle hold", result, last);

    void'($urandom(32'd1234));
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 200; k++) begin
        ra = $urandom; rb = $urandom; rc = $urandom;
        if (k % 4 == 0) ra[15:8] = 8'h00;
        if (k % 8 == 1) rc = 32'hFFFFFFF0;
        run_op($sformatf("R%0d random", m + 1), 2'(m), ra, rb, rc, ref_sad(2'(m), ra, rb, rc));
      end
    end

    // back-to-back then reset
    mode = 2'b00; src_a = 32'h01010101; src_b = 0; acc = 0; in_valid = 1'b1;
    @(negedge clk);
    src_a = 32'h02020202;
    @(negedge clk);
    check("R9 back-to-back", result, 32'd8);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R10 sync reset valid", 32'(out_valid), 0);
    check("R10 sync reset result", result, 0);
    rst = 1'b0;

    done = 1;
    print_summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      print_summary();
      $finish;
    end
  end
endmodule